// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a processor's load/store stage and a data memory organised as 32-bit words. It takes a byte-granular request (address, size, direction, signedness, store data) and turns it into one aligned word access: a word address, a four-bit lane write mask and lane-replicated write data. Byte lanes are big-endian, so the lowest byte address of a word maps to bits [31:24] and the highest to bits [7:0].

Loads are split over two cycles. In the first cycle the request goes to a memory with a registered read port. In the second cycle the returned word passes through a lane selector and a sign or zero extender. The lane offset, size and signedness of the accepted load are held in registers, so the result is combinational from the read data in the cycle after issue. A two-state controller tracks this. `ST_IDLE` means no response is pending, and `ST_RESP` means a load result is valid this cycle. The transitions are T_HOLD (ST_IDLE to ST_IDLE, no load accepted), T_ISSUE (ST_IDLE to ST_RESP, load accepted), T_CHAIN (ST_RESP to ST_RESP, a further load accepted back to back) and T_DRAIN (ST_RESP to ST_IDLE, no load accepted).

A request whose address does not suit its size raises a combinational error flag. That request reaches neither the memory nor the response path.

Top module: `lsa_top`

## Requirements
- R1: `mem_addr` always equals `req_addr` with its two least significant bits removed.
- R2: An aligned byte store (size code 0) drives exactly one write-enable bit. Offset 0 drives 4'b1000 and offset 3 drives 4'b0001, where bit 3 controls bits [31:24]. `mem_wdata` carries the low byte of `req_wdata` in all four lanes, and the other bytes of the memory word stay unchanged.
- R3: An aligned halfword store (size code 1) drives 4'b1100 at offset 0 and 4'b0011 at offset 2. `mem_wdata` carries the low halfword of `req_wdata` in both halves.
- R4: An aligned word store (size code 2) drives 4'b1111 and passes `req_wdata` unchanged.
- R5: `misalign` is 1 for a valid halfword request with address bit 0 set, for a valid word request with a nonzero offset, and for the reserved size code 3. While it is 1, `mem_en` and `mem_we` are 0.
- R6: A load never drives any write-enable bit. `ld_valid` is 1 in exactly the cycle after an accepted load (valid, aligned, not a store), and is 0 after stores, misaligned requests and idle cycles.
- R7: A byte load returns the lane selected big-endian by the registered offset: offset 0 gives bits [31:24] and offset 3 gives bits [7:0].
- R8: A halfword load returns bits [31:16] for offset 0 and bits [15:0] for offset 2.
- R9: With `req_signed` = 1, byte and halfword loads copy the top bit of the selected field into all higher result bits. With `req_signed` = 0, those bits are zero.
- R10: A word load returns `mem_rdata` unchanged, whatever the signedness.
- R11: When loads are accepted in back-to-back cycles, each result uses the offset, size and signedness of its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | 1 = sign-extend a narrow load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_addr | output | ADDR_W-2 | Word address to memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word read from memory, one cycle after `mem_en` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |
| misalign | output | 1 | Misaligned or illegal-size request |

## Verification
Every cycle, the assertions check several properties. The write mask stays zero for loads and for flagged requests, and a flagged request never enables memory. A byte store drives one lane and a halfword store drives two. `ld_valid` follows exactly one cycle after each accepted load. An unsigned narrow result has zero upper bits, and the word address tracks the byte address. Only the bench scenarios can show the rest, because it depends on memory contents and the order of requests. The bench shows which big-endian lane is selected for each offset, that the value returned by sign extension is correct, that memory lanes outside the mask survive a store, that a rejected store leaves memory unchanged, and that back-to-back loads keep their own offsets.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/lsa_lane_decode.sv
module lsa_lane_decode
    import lsa_pkg::*;
(
    input  logic             valid,
    input  logic             store,
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             err,
    output logic [LANES-1:0] mask,
    output logic [LANES-1:0] we
);
    acc_size_e sz;
    assign sz = acc_size_e'(size);

    always_comb begin
        err  = 1'b0;
        mask = '0;
        unique case (sz)
            SZ_BYTE: mask = LANES'(1) << (LANES - 1 - off);
            SZ_HALF: begin
                err  = off[0];
                mask = off[1] ? LANES'(4'b0011) : LANES'(4'b1100);
            end
            SZ_WORD: begin
                err  = (off != '0);
                mask = '1;
            end
            SZ_RSVD: err = 1'b1;
        endcase
        err = err & valid;
        we  = (valid && store && !err) ? mask : '0;
    end
endmodule

// File: rtl/lsa_store_pack.sv
module lsa_store_pack
    import lsa_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lanes
);
    acc_size_e sz;
    assign sz = acc_size_e'(size);

    always_comb begin
        unique case (sz)
            SZ_BYTE: lanes = {LANES{wdata[7:0]}};
            SZ_HALF: lanes = {(LANES/2){wdata[15:0]}};
            SZ_WORD: lanes = wdata;
            SZ_RSVD: lanes = wdata;
        endcase
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sgn,
    output logic [WORD_W-1:0] result
);
    logic [7:0]  lane [LANES];
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;
    acc_size_e   sz;

    assign sz = acc_size_e'(size);

    // Lane 0 is the lowest byte address, i.e. the most significant byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[WORD_W-1-8*g -: 8];
    end

    assign byte_sel = lane[off];
    assign half_sel = off[1] ? {lane[2], lane[3]} : {lane[0], lane[1]};

    always_comb begin
        unique case (sz)
            SZ_BYTE: result = {{(WORD_W-8){sgn & byte_sel[7]}}, byte_sel};
            SZ_HALF: result = {{(WORD_W-16){sgn & half_sel[15]}}, half_sel};
            SZ_WORD: result = rdata;
            SZ_RSVD: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_signed,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [ADDR_W-3:0] mem_addr,
    output logic              mem_en,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              misalign
);
    localparam int unsigned WA_W = ADDR_W - OFF_W;

    resp_state_e      state_q, state_d;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       size_q;
    logic             sgn_q;
    logic             ld_accept;
    logic [LANES-1:0] mask;

    lsa_lane_decode u_decode (
        .valid (req_valid),
        .store (req_store),
        .size  (req_size),
        .off   (req_addr[OFF_W-1:0]),
        .err   (misalign),
        .mask  (mask),
        .we    (mem_we)
    );

    lsa_store_pack u_pack (
        .size  (req_size),
        .wdata (req_wdata),
        .lanes (mem_wdata)
    );

    lsa_load_extract u_extract (
        .rdata  (mem_rdata),
        .size   (size_q),
        .off    (off_q),
        .sgn    (sgn_q),
        .result (ld_data)
    );

    assign mem_addr  = WA_W'(req_addr >> OFF_W);
    assign mem_en    = req_valid & ~misalign;
    assign ld_accept = req_valid & ~req_store & ~misalign;

    // Next-state: T_HOLD, T_ISSUE, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ld_accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ld_accept ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            size_q <= SZ_WORD;
            sgn_q  <= 1'b0;
        end else if (ld_accept) begin
            off_q  <= req_addr[OFF_W-1:0];
            size_q <= req_size;
            sgn_q  <= req_signed;
        end
    end

    always_comb begin
        ld_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ld_valid = 1'b0;
            ST_RESP: ld_valid = 1'b1;
        endcase
    end

    AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr == req_addr[ADDR_W-1:OFF_W]) else $error("addr"); // R1
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |-> $countones(mem_we) == 1) else $error("byte mask"); // R2
    AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd1 && !req_addr[0]) |-> $countones(mem_we) == 2) else $error("half mask"); // R3
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_en && mem_we == 4'b0000)) else $error("err"); // R5
    AST_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_store |-> mem_we == 4'b0000) else $error("load we"); // R6
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> ld_valid) else $error("resp"); // R6
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_accept |=> !ld_valid) else $error("spurious"); // R6
    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !sgn_q && size_q == 2'd0) |-> ld_data[31:8] == 24'd0) else $error("zext"); // R9
endmodule

// File: tb/lsa_top_tb.sv
module lsa_top_tb;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
    logic [1:0]        req_size = 2'd2;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [ADDR_W-3:0] mem_addr;
    logic              mem_en;
    logic [3:0]        mem_we;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic              ld_valid, misalign;
    logic [31:0]       ld_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    lsa_top #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_signed(req_signed), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign)
    );

    // Simple word memory, registered read, byte-lane writes.
    logic [31:0] mem [16];
    initial for (int i = 0; i < 16; i++) mem[i] = 32'd0;
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr[3:0]];
            for (int l = 0; l < 4; l++)
                if (mem_we[l]) mem[mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
    end

    function automatic logic [31:0] ref_load(input logic [31:0] w, input int off,
                                             input int size, input logic sgn);
        logic [7:0] b [4];
        logic [31:0] r;
        b[0] = w[31:24]; b[1] = w[23:16]; b[2] = w[15:8]; b[3] = w[7:0];
        if (size == 0) r = sgn ? 32'($signed(b[off])) : {24'd0, b[off]};
        else if (size == 1) r = sgn ? 32'($signed({b[off], b[off+1]})) : {16'd0, b[off], b[off+1]};
        else r = w;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        req_valid = 1'b0; req_store = 1'b0;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                            input logic [31:0] d, input logic [3:0] exp_we,
                            input logic [31:0] exp_wd, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
        #1;
        chk({tag, " we"}, 32'(mem_we), 32'(exp_we));
        if (exp_we != 4'b0000) chk({tag, " wdata"}, mem_wdata, exp_wd);
        chk("R1 word address", 32'(mem_addr), 32'(a >> 2));
        @(posedge clk);
        @(negedge clk);
        go_idle();
        chk("R6 no response after store", 32'(ld_valid), 32'd0);
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                           input logic sgn, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_addr = a; req_signed = sgn;
        #1;
        chk("R6 load has no write enable", 32'(mem_we), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid"}, 32'(ld_valid), 32'd1);
        chk(tag, ld_data, exp);
        go_idle();
    endtask

    task automatic t_reset();
        #1;
        chk("R6 reset ld_valid", 32'(ld_valid), 32'd0);
        chk("R6 reset mem_we", 32'(mem_we), 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_stores();
        do_store(12'h000, 2'd2, 32'h11223344, 4'b1111, 32'h11223344, "R4 word store");
        do_store(12'h004, 2'd2, 32'h80F07F01, 4'b1111, 32'h80F07F01, "R4 word store 2");
        do_store(12'h009, 2'd0, 32'h000000AB, 4'b0100, 32'hABABABAB, "R2 byte store off1");
        do_store(12'h030, 2'd0, 32'h0000005A, 4'b1000, 32'h5A5A5A5A, "R2 byte store off0");
        do_store(12'h033, 2'd0, 32'h000000C3, 4'b0001, 32'hC3C3C3C3, "R2 byte store off3");
        do_store(12'h00E, 2'd1, 32'h1234BEEF, 4'b0011, 32'hBEEFBEEF, "R3 half store off2");
        do_store(12'h010, 2'd1, 32'h00009876, 4'b1100, 32'h98769876, "R3 half store off0");
    endtask

    task automatic t_narrow_store_lanes();
        do_load(12'h008, 2'd2, 1'b0, 32'h00AB0000, "R2 other lanes kept");
        do_load(12'h00C, 2'd2, 1'b0, 32'h0000BEEF, "R3 other half kept");
        do_load(12'h030, 2'd2, 1'b0, 32'h5A0000C3, "R2 lanes 0 and 3");
    endtask

    task automatic t_loads();
        logic [31:0] w;
        w = 32'h80F07F01;
        do_load(12'h000, 2'd2, 1'b1, 32'h11223344, "R10 word load");
        for (int o = 0; o < 4; o++) begin
            do_load(ADDR_W'(4 + o), 2'd0, 1'b1, ref_load(w, o, 0, 1'b1), "R7 R9 byte load signed");
            do_load(ADDR_W'(4 + o), 2'd0, 1'b0, ref_load(w, o, 0, 1'b0), "R7 R9 byte load unsigned");
        end
        do_load(12'h004, 2'd1, 1'b1, 32'hFFFF80F0, "R8 R9 half off0 signed");
        do_load(12'h004, 2'd1, 1'b0, 32'h000080F0, "R8 R9 half off0 unsigned");
        do_load(12'h006, 2'd1, 1'b1, 32'h00007F01, "R8 R9 half off2 signed");
        do_load(12'h004, 2'd2, 1'b1, 32'h80F07F01, "R10 word load signed");
    endtask

    task automatic t_misalign();
        logic [1:0]        szs [3];
        logic [ADDR_W-1:0] ads [3];
        szs[0] = 2'd1; ads[0] = 12'h005;
        szs[1] = 2'd2; ads[1] = 12'h006;
        szs[2] = 2'd3; ads[2] = 12'h004;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_store = 1'b1; req_size = szs[k]; req_addr = ads[k];
            req_wdata = 32'hDEADDEAD;
            #1;
            chk("R5 misalign flag", 32'(misalign), 32'd1);
            chk("R5 mem_en low", 32'(mem_en), 32'd0);
            chk("R5 mem_we low", 32'(mem_we), 32'd0);
            @(posedge clk);
            @(negedge clk);
            go_idle();
        end
        do_load(12'h004, 2'd2, 1'b0, 32'h80F07F01, "R5 memory unchanged");
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = 2'd1; req_addr = 12'h007;
        @(posedge clk);
        @(negedge clk);
        chk("R6 no response to misaligned load", 32'(ld_valid), 32'd0);
        go_idle();
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = 2'd0; req_addr = 12'h004; req_signed = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 first of pair", ld_data, 32'hFFFFFF80);
        req_size = 2'd0; req_addr = 12'h007; req_signed = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11 second valid", 32'(ld_valid), 32'd1);
        chk("R11 second of pair", ld_data, 32'h00000001);
        req_size = 2'd1; req_addr = 12'h006; req_signed = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 third of chain", ld_data, 32'h00007F01);
        go_idle();
        @(posedge clk);
        @(negedge clk);
        chk("R6 response drains", 32'(ld_valid), 32'd0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_stores();
        t_narrow_store_lanes();
        t_loads();
        t_misalign();
        t_back_to_back();
        repeat (2) @(posedge clk);
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end
endmodule